// File: doc/BRIEF.md
# I2C Target Receiver/Transmitter with Event Flags

This block is the target side of an I2C link. It watches the serial clock and data lines for start and stop conditions and shifts in the first byte after each start. It compares that byte with a programmed 7-bit own address and, when enabled, also with the general call address. On a hit it acknowledges if acknowledging is enabled, then holds SCL low until the host has seen the event. The least significant bit of the address byte then sends it into either a receive path or a transmit path. Received bytes land in a data register. Each received byte, and each byte the remote master acknowledges, stretches the clock again until the host reads or writes that register.

The host reaches the block through a small strobe-based register bus. Register addresses: 0 control, 1 own address, 2 event register 1, 3 event register 2, 4 data. Reads return data combinationally from `reg_addr`, and side effects take place in the cycle `reg_rd` is high.

Control register bits:

| Bit | Function |
|-----|----------|
| 0 | enable |
| 1 | acknowledge enable |
| 2 | interrupt enable |
| 3 | general-call enable |

Event register 1 bits:

| Bit | Meaning |
|-----|---------|
| 0 | address-hit pending |
| 1 | byte finished |
| 2 | transmit direction |
| 3 | addressed |

Event register 2 bits:

| Bit | Meaning |
|-----|---------|
| 4 | acknowledge failure |
| 3 | stop seen |
| 2 | arbitration lost (always 0 here) |
| 1 | bus error |
| 0 | general call |

Bits 7..5 of event register 2 read as 0.

The line drivers are open-drain enables: a 1 on `scl_oe` or `sda_oe` pulls the line low.

The state machine has these states: IDLE, ADDR (address bits), AACK (address acknowledge slot), WAIT (clock held low), RX (receive bits), RACK (receive acknowledge slot), TX (transmit bits) and TACK (master acknowledge slot). Its transitions are:

- Any state goes to ADDR on a start and to IDLE on a stop.
- ADDR goes to AACK at the falling edge that ends the eighth bit if the address hits. On a miss it goes to IDLE.
- AACK goes to WAIT at the next falling edge.
- WAIT goes to RX or TX, chosen by the direction bit, once no hold reason is left.
- RX goes to RACK after eight bits, and RACK goes to WAIT at the next falling edge.
- TX goes to TACK after eight bits.
- TACK goes to WAIT when the master acknowledges, and to IDLE when it does not.

Top module: `i2c_target`

## Requirements
- R1: After reset every register reads 0x00, and `scl_oe`, `sda_oe` and `irq` are 0.
- R2: A start is SDA falling while SCL is high. If the next byte's upper seven bits equal the own address, `sda_oe` is driven high from the eighth falling SCL edge through the ninth clock. On a mismatch the block stays silent, including for later bytes, until the next start.
- R3: On an address hit, event register 1 bit 0 and bit 3 set. SCL is held low after the ninth clock until event register 1 is read.
- R4: In receive mode each byte is stored in the data register and event register 1 bit 1 sets. SCL is held low until the data register is read.
- R5: With acknowledge enable 0, a matching address byte gets no acknowledge.
- R6: Address 0x00 is accepted only when general-call enable is 1. It sets event register 2 bit 0, which a stop condition clears.
- R7: An address byte with bit 0 = 1 enters transmit mode. In that mode the data register is shifted out MSB first on SDA, and event register 1 bit 2 reads 1. A not-acknowledge from the master sets event register 2 bit 4 and returns the block to IDLE.
- R8: A stop (SDA rising while SCL is high) seen after an acknowledge slot of an addressed transfer sets event register 2 bit 3. A stop while not addressed sets nothing.
- R9: A start or stop after the second or a later bit of a data byte sets event register 2 bit 1.
- R10: Reading event register 2 clears its bits 4, 3 and 1. Bit 2 always reads 0.
- R11: `irq` is 1 exactly when interrupt enable is 1 and any of address-hit pending, byte finished, acknowledge failure, stop seen or bus error is set.
- R12: Clearing the enable bit clears every event flag and releases SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_addr | input | 3 | host register address |
| reg_wr | input | 1 | host write strobe |
| reg_rd | input | 1 | host read strobe (triggers read side effects) |
| reg_wdata | input | 8 | host write data |
| reg_rdata | output | 8 | host read data |
| irq | output | 1 | interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | pull SCL low when 1 |
| sda_oe | output | 1 | pull SDA low when 1 |

## Verification
A wrong state or bit count shows up at the ports quickly. It moves the acknowledge into the wrong clock, so the master sees the wrong ACK level within one byte. It also leaves SCL held or released at the wrong moment, which a master watching the line sees within about twenty clocks of the ninth edge. A flag that is set or cleared wrongly shows in the next host read of an event register, and at once on `irq`. Bus errors only show after a stop or start placed mid-byte, so those are injected on purpose.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WAIT,
        ST_RX,   ST_RACK, ST_TX,   ST_TACK
    } tgt_state_e;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_OWN  = 3'd1;
    localparam logic [2:0] RA_EVT1 = 3'd2;
    localparam logic [2:0] RA_EVT2 = 3'd3;
    localparam logic [2:0] RA_DATA = 3'd4;

    localparam int CB_EN  = 0;
    localparam int CB_ACK = 1;
    localparam int CB_IRQ = 2;
    localparam int CB_GC  = 3;
endpackage

// File: rtl/i2c_target_sync.sv
module i2c_target_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_chain, sda_chain;
    logic              scl_prev,  sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_prev  <= scl_chain[STAGES-1];
            sda_prev  <= sda_chain[STAGES-1];
        end
    end

    assign scl_s    = scl_chain[STAGES-1];
    assign sda_s    = sda_chain[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;
    assign start_c  = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_c   = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_target_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ack_en,
    input  logic          gc_en,
    input  logic [AW-1:0] own_addr,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_c,
    input  logic          stop_c,
    input  logic          hold_req,
    input  logic [BW-1:0] tx_byte,
    output logic [BW-1:0] rx_byte,
    output logic          ev_match,
    output logic          ev_gcall,
    output logic          ev_rxbyte,
    output logic          ev_btf,
    output logic          ev_af,
    output logic          ev_stop,
    output logic          ev_berr,
    output logic          addressed,
    output logic          tx_mode,
    output logic          sda_oe,
    output logic          scl_oe
);
    localparam int             CNT_W = $clog2(BW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BW);

    tgt_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [BW-1:0]    sr, tx_sr;
    logic             dir_q, mack_q;
    logic             own_hit, gc_hit, mid_byte;

    assign own_hit  = (sr[BW-1:1] == own_addr) && !sr[0] ? 1'b1 : (sr[BW-1:1] == own_addr);
    assign gc_hit   = gc_en && (sr == '0);
    assign mid_byte = (state == ST_RX || state == ST_TX) && (cnt > CNT_W'(1));

    // next state and one-cycle events
    always_comb begin
        nxt       = state;
        ev_match  = 1'b0;
        ev_gcall  = 1'b0;
        ev_rxbyte = 1'b0;
        ev_btf    = 1'b0;
        ev_af     = 1'b0;
        ev_stop   = 1'b0;
        ev_berr   = 1'b0;
        if (stop_c) begin
            nxt = ST_IDLE;
            if (mid_byte)                                  ev_berr = 1'b1;
            else if (state != ST_IDLE && state != ST_ADDR) ev_stop = 1'b1;
        end else if (start_c) begin
            nxt     = ST_ADDR;
            ev_berr = mid_byte;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: if (scl_fall && cnt == LAST) begin
                    if (own_hit || gc_hit) begin
                        nxt      = ST_AACK;
                        ev_match = 1'b1;
                        ev_gcall = gc_hit;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_AACK: if (scl_fall) nxt = ST_WAIT;
                ST_WAIT: if (!hold_req) nxt = dir_q ? ST_TX : ST_RX;
                ST_RX:   if (scl_fall && cnt == LAST) begin
                    nxt       = ST_RACK;
                    ev_rxbyte = 1'b1;
                end
                ST_RACK: if (scl_fall) begin
                    nxt    = ST_WAIT;
                    ev_btf = 1'b1;
                end
                ST_TX:   if (scl_fall && cnt == LAST) nxt = ST_TACK;
                ST_TACK: if (scl_fall) begin
                    if (mack_q) begin
                        nxt   = ST_IDLE;
                        ev_af = 1'b1;
                    end else begin
                        nxt    = ST_WAIT;
                        ev_btf = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sr     <= '0;
            tx_sr  <= '0;
            dir_q  <= 1'b0;
            mack_q <= 1'b0;
        end else if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (start_c || nxt != state)
                cnt <= '0;
            else if (scl_rise && (state == ST_ADDR || state == ST_RX || state == ST_TX))
                cnt <= cnt + CNT_W'(1);
            if (scl_rise && (state == ST_ADDR || state == ST_RX))
                sr <= {sr[BW-2:0], sda_s};
            if (state == ST_ADDR && nxt == ST_AACK)
                dir_q <= sr[0];
            if (state == ST_WAIT && nxt == ST_TX)
                tx_sr <= tx_byte;
            else if (state == ST_TX && scl_fall)
                tx_sr <= {tx_sr[BW-2:0], 1'b0};
            if (state == ST_TACK && scl_rise)
                mack_q <= sda_s;
        end
    end

    // outputs decoded from state
    always_comb begin
        addressed = (state != ST_IDLE) && (state != ST_ADDR);
        tx_mode   = dir_q && addressed;
        scl_oe    = (state == ST_WAIT);
        sda_oe    = ((state == ST_AACK || state == ST_RACK) && ack_en) ||
                    (state == ST_TX && !tx_sr[BW-1]);
        rx_byte   = sr;
    end
endmodule

// File: rtl/i2c_target.sv
module i2c_target
    import i2c_target_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int BW = BYTE_W;
    localparam int AW = ADDR_W;

    logic [3:0]    ctrl_q;
    logic [AW-1:0] own_q;
    logic [BW-1:0] data_q, rx_byte;
    logic          adr_pend, btf, af, stopf, berr, gcall;
    logic          scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic          ev_match, ev_gcall, ev_rxbyte, ev_btf, ev_af, ev_stop, ev_berr;
    logic          addressed, tx_mode, hold_req, en;
    logic          rd_evt1, rd_evt2, rd_data, wr_data;

    assign en       = ctrl_q[CB_EN];
    assign hold_req = adr_pend | btf;
    assign rd_evt1  = reg_rd && reg_addr == RA_EVT1;
    assign rd_evt2  = reg_rd && reg_addr == RA_EVT2;
    assign rd_data  = reg_rd && reg_addr == RA_DATA;
    assign wr_data  = reg_wr && reg_addr == RA_DATA;

    i2c_target_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    i2c_target_fsm #(.BW(BW), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en),
        .ack_en(ctrl_q[CB_ACK]), .gc_en(ctrl_q[CB_GC]), .own_addr(own_q),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c), .hold_req(hold_req),
        .tx_byte(data_q), .rx_byte(rx_byte),
        .ev_match(ev_match), .ev_gcall(ev_gcall), .ev_rxbyte(ev_rxbyte),
        .ev_btf(ev_btf), .ev_af(ev_af), .ev_stop(ev_stop), .ev_berr(ev_berr),
        .addressed(addressed), .tx_mode(tx_mode), .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            own_q  <= '0;
            data_q <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    RA_CTRL: ctrl_q <= reg_wdata[3:0];
                    RA_OWN:  own_q  <= reg_wdata[AW-1:0];
                    RA_DATA: data_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (ev_rxbyte) data_q <= rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {adr_pend, btf, af, stopf, berr, gcall} <= '0;
        end else if (!en) begin
            {adr_pend, btf, af, stopf, berr, gcall} <= '0;
        end else begin
            if (ev_match)               adr_pend <= 1'b1;
            else if (rd_evt1)           adr_pend <= 1'b0;
            if (ev_btf)                 btf      <= 1'b1;
            else if (rd_data || wr_data) btf     <= 1'b0;
            if (ev_af)                  af       <= 1'b1;
            else if (rd_evt2)           af       <= 1'b0;
            if (ev_stop)                stopf    <= 1'b1;
            else if (rd_evt2)           stopf    <= 1'b0;
            if (ev_berr)                berr     <= 1'b1;
            else if (rd_evt2)           berr     <= 1'b0;
            if (ev_gcall)               gcall    <= 1'b1;
            else if (stop_c)            gcall    <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {4'b0, ctrl_q};
            RA_OWN:  reg_rdata = {1'b0, own_q};
            RA_EVT1: reg_rdata = {4'b0, addressed, tx_mode, btf, adr_pend};
            RA_EVT2: reg_rdata = {3'b0, af, stopf, 1'b0, berr, gcall};
            RA_DATA: reg_rdata = data_q;
            default: reg_rdata = 8'h00;
        endcase
    end

    assign irq = ctrl_q[CB_IRQ] & (adr_pend | btf | af | stopf | berr);
endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_sync,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       hold_req,
    input logic       irq,
    input logic       irq_en,
    input logic       gc_en,
    input logic       en,
    input logic       cond_seen,
    input logic [5:0] flags
);
    // R2: SDA is only pulled low while the synchronized clock is low
    p_sda_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_sync);

    // R3 / R4: the clock hold ends one cycle after the last hold reason clears
    p_hold_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !hold_req) |=> !scl_oe);

    // R6: general-call flag only rises while general call is enabled
    p_gcall_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> gc_en);

    // R9: bus error only follows a start or stop condition
    p_berr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(cond_seen));

    // R11: no interrupt while interrupts are disabled
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R12: disabling the block empties every flag
    p_disable_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (flags == 6'b0));
endmodule

bind i2c_target i2c_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl_s), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .hold_req(hold_req), .irq(irq), .irq_en(ctrl_q[2]), .gc_en(ctrl_q[3]),
    .en(ctrl_q[0]), .cond_seen(start_c | stop_c),
    .flags({adr_pend, btf, af, stopf, berr, gcall})
);

// File: tb/sim_i2c_target.sv
module sim_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int QT = 8;
    localparam int HT = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic read_chk(input logic [2:0] a, input int exp, input string req);
        logic [7:0] d;
        bus_read(a, d);
        chk(req, int'(d), exp);
    endtask

    task automatic i_start();
        m_sda_low = 1'b1; hold(HT);
        m_scl_low = 1'b1; hold(QT);
    endtask

    task automatic i_stop();
        m_sda_low = 1'b1; hold(QT);
        m_scl_low = 1'b0; wait (scl_line == 1'b1); hold(HT);
        m_sda_low = 1'b0; hold(HT);
    endtask

    task automatic bit_out(input logic b);
        m_sda_low = !b; hold(QT);
        m_scl_low = 1'b0; wait (scl_line == 1'b1); hold(HT);
        m_scl_low = 1'b1; hold(QT);
    endtask

    task automatic bit_in(output logic b);
        m_sda_low = 1'b0; hold(QT);
        m_scl_low = 1'b0; wait (scl_line == 1'b1); hold(HT / 2);
        b = sda_line; hold(HT / 2);
        m_scl_low = 1'b1; hold(QT);
    endtask

    task automatic send_bits(input logic [7:0] v, input int top, output logic ack);
        for (int i = top; i >= 0; i--) bit_out(v[i]);
        bit_in(ack);
    endtask

    // first bit of a byte clocked while the target is stretching; a host read releases it
    task automatic held_first(input logic b7, input logic [2:0] a, input int exp, input string req);
        logic [7:0] d;
        m_sda_low = !b7; hold(QT);
        m_scl_low = 1'b0; hold(20);
        chk({req, " clock held"}, int'(scl_line), 0);
        bus_read(a, d);
        chk({req, " read while held"}, int'(d), exp);
        wait (scl_line == 1'b1); hold(HT);
        m_scl_low = 1'b1; hold(QT);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rxv;
        hold(5);
        // R1 reset state
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 irq", int'(irq), 0);
        for (int r = 0; r < 5; r++) read_chk(3'(r), 0, "R1 register reset");
        rst_n = 1'b1;
        hold(3);
        for (int r = 0; r < 5; r++) read_chk(3'(r), 0, "R1 register after reset");

        bus_write(3'd1, 8'h3A);
        bus_write(3'd0, 8'h07);

        // R2 mismatch: no ACK, later bytes ignored
        i_start();
        send_bits(8'h50, 7, ack);
        chk("R2 mismatch nack", int'(ack), 1);
        send_bits(8'h74, 7, ack);
        chk("R2 ignored until start", int'(ack), 1);
        i_stop();
        read_chk(3'd2, 8'h00, "R2 evt1 after mismatch");
        read_chk(3'd3, 8'h00, "R8 unaddressed stop");

        // R2/R3/R4 matched write with stretching
        i_start();
        send_bits(8'h74, 7, ack);
        chk("R2 address ack", int'(ack), 0);
        chk("R11 irq on hit", int'(irq), 1);
        held_first(1'b1, 3'd2, 8'h09, "R3");
        send_bits(8'hC5, 6, ack);
        chk("R4 data ack", int'(ack), 0);
        read_chk(3'd2, 8'h0A, "R4 btf in evt1");
        held_first(1'b0, 3'd4, 8'hC5, "R4");
        send_bits(8'h5E, 6, ack);
        chk("R4 second ack", int'(ack), 0);
        read_chk(3'd4, 8'h5E, "R4 second byte");
        i_stop();
        chk("R11 irq on stop", int'(irq), 1);
        read_chk(3'd3, 8'h08, "R8 stop flag");
        read_chk(3'd3, 8'h00, "R10 cleared by read");
        chk("R11 irq cleared", int'(irq), 0);

        // R5 acknowledge disabled
        bus_write(3'd0, 8'h05);
        i_start();
        send_bits(8'h74, 7, ack);
        chk("R5 no ack", int'(ack), 1);
        read_chk(3'd2, 8'h09, "R5 still addressed");
        i_stop();
        read_chk(3'd3, 8'h08, "R8 stop after nack");
        bus_write(3'd0, 8'h07);

        // R6 general call gating
        i_start();
        send_bits(8'h00, 7, ack);
        chk("R6 gc disabled nack", int'(ack), 1);
        i_stop();
        read_chk(3'd3, 8'h00, "R6 no gcall flag");
        bus_write(3'd0, 8'h0F);
        i_start();
        send_bits(8'h00, 7, ack);
        chk("R6 gc enabled ack", int'(ack), 0);
        read_chk(3'd3, 8'h01, "R6 gcall flag");
        read_chk(3'd2, 8'h09, "R6 addressed");
        send_bits(8'h11, 7, ack);
        chk("R6 gc data ack", int'(ack), 0);
        read_chk(3'd4, 8'h11, "R6 gc data");
        i_stop();
        read_chk(3'd3, 8'h08, "R6 gcall cleared by stop");
        bus_write(3'd0, 8'h07);

        // R7 transmit
        bus_write(3'd4, 8'hA6);
        i_start();
        send_bits(8'h75, 7, ack);
        chk("R7 read address ack", int'(ack), 0);
        read_chk(3'd2, 8'h0D, "R7 transmit direction");
        rxv = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            bit_in(ack);
            rxv[i] = ack;
        end
        chk("R7 shifted byte", int'(rxv), 8'hA6);
        bit_out(1'b1);
        i_stop();
        read_chk(3'd3, 8'h10, "R7 ack failure");

        // R9 bus error mid-byte
        i_start();
        send_bits(8'h74, 7, ack);
        read_chk(3'd2, 8'h09, "R9 addressed");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        i_stop();
        chk("R11 irq on berr", int'(irq), 1);
        read_chk(3'd3, 8'h02, "R9 bus error");
        read_chk(3'd3, 8'h00, "R10 berr cleared");

        // R11 gating and R12 disable while held
        bus_write(3'd0, 8'h03);
        i_start();
        send_bits(8'h74, 7, ack);
        hold(4);
        chk("R11 irq masked", int'(irq), 0);
        chk("R3 scl held", int'(scl_oe), 1);
        bus_write(3'd0, 8'h02);
        hold(2);
        chk("R12 scl released", int'(scl_oe), 0);
        read_chk(3'd2, 8'h00, "R12 evt1 cleared");
        read_chk(3'd3, 8'h00, "R12 evt2 cleared");
        i_stop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule